// File: doc/BRIEF.md
# Programmable SPI Master Channel

A single-channel serial-peripheral master controlled through a small word-wide register port. Software selects the clock mode, a word length between 4 and 32 bits, a power-of-two clock divider, one of three transfer modes (full duplex, receive-only or transmit-only), a chip-select level that it holds by hand, and which of the two data pins is the output. The data path has one transmit holding register, one shifter and one receive holding register. Status bits report an empty transmit register, an unread receive word, the end of a word with the shifter idle, and the completion of a soft reset.

After a reset the channel is a bus slave: it drives neither data pin and does not clock the bus until software sets the master-select bit. Shifting happens only while the channel enable is set. Clearing the enable lets the word in flight finish and starts no further word.

Top module: `spim_channel`

## Requirements
- R1: After reset, CFG (address 0) reads 0x3C0, STAT (address 2) reads 0xA, SYS (address 5) reads 0, chip select is at its inactive level 1, SCLK is 0 and neither data pin is driven. CFG fields: [0] phase, [1] clock idle level, [5:2] divider code, [6] chip-select active-low, [11:7] length minus 1, [13:12] transfer mode, [14] pin swap, [15] chip-select force. CTRL (address 1) bit 0 is the enable. TXD is address 3 and RXD is address 4. SYS bit 0 is the soft reset (write) and bit 1 is master select. STAT bits: [0] RXS, [1] TXS, [2] EOT, [3] reset-done.
- R2: With divider code n (n up to 12) each SCLK half-period lasts 2^n reference cycles. Codes 13 to 15 behave as 12.
- R3: SCLK rests at the idle-level bit between words. With phase 0 both sides sample on the first edge of each bit, and with phase 1 on the second edge. Words go out and come in most significant bit first.
- R4: A word is (length field + 1) bits long, from 4 to 32 bits. A received word is right-aligned and zero-extended in RXD.
- R5: In full duplex (mode 0) the TXD word is shifted out, the word shifted in lands in RXD and sets RXS, and reading RXD clears RXS.
- R6: In transmit-only mode (mode 2) RXS is not raised and RXD keeps its previous content.
- R7: In receive-only mode (mode 1) a single TXD write starts back-to-back words that drive zeros on the output pin. Each word received sets RXS. After the enable is cleared, the word in flight completes and no further word starts.
- R8: TXS goes to 0 on a TXD write and returns to 1 when the shifter takes the word.
- R9: EOT is 1 once the last edge of a word has passed with no new word started, and it is 0 while a word is shifting.
- R10: In master mode, with the force bit set, chip select is 0 when the active-low bit is set and 1 when it is clear. With the force bit clear, chip select sits at the opposite level.
- R11: With swap at 0 the output goes on D1 and D0 is sampled. With swap at 1 the output goes on D0 and D1 is sampled. Only the output pin has its enable set, and only in master mode.
- R12: Writing SYS bit 0 returns every register to its reset value. Reset-done reads 0 in the cycle after the write and 1 from the following cycle on.
- R13: No word starts while the channel is in slave mode or the enable is clear. A pending TXD word then keeps TXS at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears RXS when reading RXD) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| sclk | output | 1 | Serial clock |
| cs | output | 1 | Chip select |
| d0_o | output | 1 | Data pin 0 output value |
| d0_oe | output | 1 | Data pin 0 output enable |
| d0_i | input | 1 | Data pin 0 input |
| d1_o | output | 1 | Data pin 1 output value |
| d1_oe | output | 1 | Data pin 1 output enable |
| d1_i | input | 1 | Data pin 1 input |

## Verification
The hardest case to reach from the ports is the enable being cleared in receive-only mode while a word is in flight. That word must complete and no further word may start. The bench runs the receive-only stream at divider code 2, reads three words as they arrive, and clears the enable right after the third read. At that point the fourth word has started but not finished. A bench slave model that counts sampling edges then shows that exactly four words were clocked, that all of them carried zeros out, and that the fourth word still reached RXD.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int MAXW   = 32;
  localparam int LEN_W  = $clog2(MAXW) + 1;
  localparam int EDGE_W = LEN_W + 1;
  localparam int AW     = 3;
  localparam int CFG_W  = 16;
  localparam int MAX_CODE = 12;

  localparam logic [AW-1:0] A_CFG  = 3'd0;
  localparam logic [AW-1:0] A_CTRL = 3'd1;
  localparam logic [AW-1:0] A_STAT = 3'd2;
  localparam logic [AW-1:0] A_TXD  = 3'd3;
  localparam logic [AW-1:0] A_RXD  = 3'd4;
  localparam logic [AW-1:0] A_SYS  = 3'd5;

  typedef enum logic [1:0] {
    XM_DUPLEX = 2'd0,
    XM_RXONLY = 2'd1,
    XM_TXONLY = 2'd2,
    XM_SPARE  = 2'd3
  } xmode_e;

  typedef struct packed {
    logic       force_cs;
    logic       swap;
    xmode_e     mode;
    logic [4:0] wl;
    logic       low_act;
    logic [3:0] clkd;
    logic       pol;
    logic       pha;
  } cfg_t;

  localparam cfg_t CFG_RST = cfg_t'(16'h03C0);
endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen
  import spim_pkg::*;
#(
  parameter int MAXC = MAX_CODE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] clkd,
  output logic       tick
);
  localparam int CW = (MAXC > 0) ? MAXC : 1;

  logic [CW-1:0] cnt_q, cnt_d, limit;
  logic [3:0]    eff;

  always_comb begin
    eff   = (clkd > 4'(MAXC)) ? 4'(MAXC) : clkd;
    limit = {CW{1'b1}} >> (CW - int'(eff));
    tick  = run && (cnt_q == limit);
    cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             go,
  input  logic             tick,
  input  logic             pha,
  input  logic             pol,
  input  xmode_e           mode,
  input  logic [LEN_W-1:0] len,
  input  logic [MAXW-1:0]  tx_word,
  input  logic             sdi,
  output logic             busy,
  output logic             load,
  output logic             done,
  output logic [MAXW-1:0]  rx_word,
  output logic             sclk,
  output logic             sdo
);
  logic              busy_q, busy_d, lvl_q, lvl_d;
  logic [EDGE_W-1:0] ecnt_q, ecnt_d, last;
  logic [MAXW-1:0]   txsh_q, txsh_d, rxsh_q, rxsh_d;
  logic              lead, samp, shft;

  always_comb begin
    busy_d = busy_q;
    lvl_d  = lvl_q;
    ecnt_d = ecnt_q;
    txsh_d = txsh_q;
    rxsh_d = rxsh_q;
    load   = 1'b0;
    done   = 1'b0;
    last   = {len, 1'b0} - EDGE_W'(1);
    lead   = ~ecnt_q[0];
    samp   = pha ? ~lead : lead;
    shft   = pha ? (lead && (ecnt_q != '0)) : ~lead;
    if (srst) begin
      busy_d = 1'b0;
      lvl_d  = 1'b0;
      ecnt_d = '0;
      txsh_d = '0;
      rxsh_d = '0;
    end else if (!busy_q) begin
      if (go) begin
        busy_d = 1'b1;
        lvl_d  = 1'b0;
        ecnt_d = '0;
        rxsh_d = '0;
        txsh_d = (mode == XM_RXONLY) ? '0 : (tx_word << (LEN_W'(MAXW) - len));
        load   = 1'b1;
      end
    end else if (tick) begin
      lvl_d = ~lvl_q;
      if (samp) rxsh_d = {rxsh_q[MAXW-2:0], sdi};
      if (shft) txsh_d = {txsh_q[MAXW-2:0], 1'b0};
      if (ecnt_q == last) begin
        busy_d = 1'b0;
        done   = 1'b1;
      end else begin
        ecnt_d = ecnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lvl_q  <= 1'b0;
      ecnt_q <= '0;
      txsh_q <= '0;
      rxsh_q <= '0;
    end else begin
      busy_q <= busy_d;
      lvl_q  <= lvl_d;
      ecnt_q <= ecnt_d;
      txsh_q <= txsh_d;
      rxsh_q <= rxsh_d;
    end
  end

  assign busy    = busy_q;
  assign rx_word = rxsh_d;
  assign sclk    = pol ^ lvl_q;
  assign sdo     = txsh_q[MAXW-1];
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [MAXW-1:0]  reg_wdata,
  output logic [MAXW-1:0]  reg_rdata,
  input  logic             load,
  input  logic             done,
  input  logic [MAXW-1:0]  rx_word,
  output cfg_t             cfg,
  output logic [LEN_W-1:0] len,
  output logic [MAXW-1:0]  tx_word,
  output logic             go,
  output logic             master,
  output logic             srst,
  output logic             txs,
  output logic             rxs,
  output logic             eot,
  output logic             rdone
);
  cfg_t            cfg_q, cfg_d;
  logic            en_q, en_d, ms_q, ms_d, txs_q, txs_d, rxs_q, rxs_d;
  logic            eot_q, eot_d, arm_q, arm_d, rdn_q, rdn_d, srst_q, srst_d;
  logic [MAXW-1:0] txb_q, txb_d, rxb_q, rxb_d;
  logic            wr_sys_rst;

  assign wr_sys_rst = reg_wr && (reg_addr == A_SYS) && reg_wdata[0];

  always_comb begin
    cfg_d = cfg_q;  en_d = en_q;   ms_d = ms_q;   txb_d = txb_q;
    txs_d = txs_q;  rxb_d = rxb_q; rxs_d = rxs_q; eot_d = eot_q;
    arm_d = arm_q;  rdn_d = rdn_q; srst_d = 1'b0;
    if (load) begin
      txs_d = 1'b1;
      eot_d = 1'b0;
    end
    if (reg_rd && (reg_addr == A_RXD)) rxs_d = 1'b0;
    if (done) begin
      eot_d = 1'b1;
      if (cfg_q.mode != XM_TXONLY) begin
        rxb_d = rx_word;
        rxs_d = 1'b1;
      end
    end
    if (reg_wr) begin
      case (reg_addr)
        A_CFG:  cfg_d = cfg_t'(reg_wdata[CFG_W-1:0]);
        A_CTRL: begin
          en_d = reg_wdata[0];
          if (!reg_wdata[0]) arm_d = 1'b0;
        end
        A_TXD: begin
          txb_d = reg_wdata;
          txs_d = 1'b0;
          arm_d = 1'b1;
        end
        A_SYS:  ms_d = reg_wdata[1];
        default: ;
      endcase
    end
    if (srst_q) rdn_d = 1'b1;
    if (wr_sys_rst) begin
      cfg_d = CFG_RST; en_d = 1'b0; ms_d = 1'b0; txb_d = '0; txs_d = 1'b1;
      rxb_d = '0; rxs_d = 1'b0; eot_d = 1'b0; arm_d = 1'b0;
      rdn_d = 1'b0; srst_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST; en_q <= 1'b0; ms_q <= 1'b0; txb_q <= '0; txs_q <= 1'b1;
      rxb_q <= '0; rxs_q <= 1'b0; eot_q <= 1'b0; arm_q <= 1'b0;
      rdn_q <= 1'b1; srst_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d; en_q <= en_d; ms_q <= ms_d; txb_q <= txb_d; txs_q <= txs_d;
      rxb_q <= rxb_d; rxs_q <= rxs_d; eot_q <= eot_d; arm_q <= arm_d;
      rdn_q <= rdn_d; srst_q <= srst_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG:  reg_rdata = MAXW'(cfg_q);
      A_CTRL: reg_rdata = MAXW'(en_q);
      A_STAT: reg_rdata = MAXW'({rdn_q, eot_q, txs_q, rxs_q});
      A_TXD:  reg_rdata = txb_q;
      A_RXD:  reg_rdata = rxb_q;
      A_SYS:  reg_rdata = MAXW'({ms_q, 1'b0});
      default: reg_rdata = '0;
    endcase
  end

  assign cfg     = cfg_q;
  assign len     = (cfg_q.wl < 5'd3) ? LEN_W'(4) : LEN_W'(cfg_q.wl) + 1'b1;
  assign tx_word = txb_q;
  assign go      = en_q && ms_q && ((cfg_q.mode == XM_RXONLY) ? arm_q : !txs_q);
  assign master  = ms_q;
  assign srst    = srst_q;
  assign txs     = txs_q;
  assign rxs     = rxs_q;
  assign eot     = eot_q;
  assign rdone   = rdn_q;
endmodule

// File: rtl/spim_channel.sv
module spim_channel
  import spim_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [MAXW-1:0] reg_wdata,
  output logic [MAXW-1:0] reg_rdata,
  output logic            sclk,
  output logic            cs,
  output logic            d0_o,
  output logic            d0_oe,
  input  logic            d0_i,
  output logic            d1_o,
  output logic            d1_oe,
  input  logic            d1_i
);
  logic [1:0]       rsync_q;
  logic             rst_i_n;
  cfg_t             cfg_q;
  logic [LEN_W-1:0] len;
  logic [MAXW-1:0]  tx_word, rx_word;
  logic             go, master, srst, txs, rxs, eot, rdone;
  logic             sh_busy, load, done, tick, sdi, sdo, cs_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  spim_regs u_regs (
    .clk(clk), .rst_n(rst_i_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .load(load), .done(done), .rx_word(rx_word), .cfg(cfg_q), .len(len),
    .tx_word(tx_word), .go(go), .master(master), .srst(srst),
    .txs(txs), .rxs(rxs), .eot(eot), .rdone(rdone)
  );

  spim_clkgen #(.MAXC(MAX_CODE)) u_clk (
    .clk(clk), .rst_n(rst_i_n), .run(sh_busy && !srst), .clkd(cfg_q.clkd), .tick(tick)
  );

  spim_shifter u_shift (
    .clk(clk), .rst_n(rst_i_n), .srst(srst), .go(go), .tick(tick),
    .pha(cfg_q.pha), .pol(cfg_q.pol), .mode(cfg_q.mode), .len(len),
    .tx_word(tx_word), .sdi(sdi), .busy(sh_busy), .load(load), .done(done),
    .rx_word(rx_word), .sclk(sclk), .sdo(sdo)
  );

  assign sdi   = cfg_q.swap ? d1_i : d0_i;
  assign cs_on = master && cfg_q.force_cs;
  assign cs    = cfg_q.low_act ? ~cs_on : cs_on;
  assign d0_o  = sdo;
  assign d1_o  = sdo;
  assign d0_oe = master && cfg_q.swap;
  assign d1_oe = master && !cfg_q.swap;
endmodule

// File: rtl/spim_channel_chk.sv
module spim_channel_chk
  import spim_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            sclk,
  input cfg_t            cfg,
  input logic            txs,
  input logic            rxs,
  input logic            eot,
  input logic            rdone,
  input logic            master,
  input logic            reg_wr,
  input logic [AW-1:0]   reg_addr,
  input logic [MAXW-1:0] reg_wdata
);
  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cfg.pol));
  // R6
  txonly_norxs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxs) |-> ($past(cfg.mode) != XM_TXONLY));
  // R8
  txs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_TXD) |=> !txs);
  // R9
  eot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> !busy);
  // R12
  rdone_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_SYS && reg_wdata[0]) |=> !rdone);
  // R12
  rdone_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdone |=> rdone);
  // R13
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && !busy) |=> !busy);
endmodule

bind spim_channel spim_channel_chk u_chk (
  .clk(clk), .rst_n(rst_i_n), .busy(sh_busy), .sclk(sclk), .cfg(cfg_q),
  .txs(txs), .rxs(rxs), .eot(eot), .rdone(rdone), .master(master),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/spim_channel_bench.sv
`timescale 1ns/1ps
module spim_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        sclk, cs, d0_o, d0_oe, d0_i, d1_o, d1_oe, d1_i;

  int nchk = 0, nerr = 0, nedge = 0;
  bit finished = 0;

  // bench slave model
  bit          s_act = 0, s_cpol = 0, s_cpha = 0, b_swap = 0;
  int          s_len = 8, s_ns = 0, s_wi = 0;
  logic [31:0] s_words [8];
  logic [31:0] s_cap [8];
  logic [31:0] s_rx = '0;
  logic        miso, mosi;

  spim_channel u_spim_channel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk(sclk), .cs(cs), .d0_o(d0_o), .d0_oe(d0_oe), .d0_i(d0_i),
    .d1_o(d1_o), .d1_oe(d1_oe), .d1_i(d1_i)
  );

  always #5 clk = ~clk;

  assign mosi = b_swap ? d0_o : d1_o;
  assign miso = s_words[s_wi[2:0]][(s_len - 1 - s_ns) & 31];
  assign d0_i = b_swap ? 1'b0 : miso;
  assign d1_i = b_swap ? miso : 1'b0;

  always @(sclk) begin
    nedge++;
    if (s_act && (sclk == !(s_cpol ^ s_cpha))) begin
      s_rx = {s_rx[30:0], mosi};
      s_ns++;
      if (s_ns == s_len) begin
        s_cap[s_wi[2:0]] = s_rx;
        s_rx = '0;
        s_ns = 0;
        s_wi++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_stat(input int b);
    logic [31:0] s;
    s = '0;
    while (!s[b]) rd(3'd2, s);
  endtask

  function automatic logic [31:0] mkcfg(input bit frc, input bit swp, input int mode,
      input int len, input bit lowact, input int clkd, input bit pol, input bit pha);
    return {16'b0, frc, swp, 2'(mode), 5'(len - 1), lowact, 4'(clkd), pol, pha};
  endfunction

  function automatic logic [31:0] msk(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
  endfunction

  task automatic set_cfg(input logic [31:0] c);
    s_act = 0;
    wr(3'd0, c);
    s_cpha = c[0]; s_cpol = c[1]; s_len = int'(c[11:7]) + 1; b_swap = c[14];
  endtask

  task automatic arm_slave(input logic [31:0] w0);
    s_words[0] = w0; s_wi = 0; s_ns = 0; s_rx = '0;
    for (int i = 0; i < 8; i++) s_cap[i] = '0;
    s_act = 1;
  endtask

  // one word with the current configuration; returns RXD content
  task automatic one_word(input logic [31:0] txw, input logic [31:0] sw, output logic [31:0] rxv);
    arm_slave(sw);
    wr(3'd3, txw);
    wait_stat(1);
    wait_stat(2);
    s_act = 0;
    rd(3'd4, rxv);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd0, v); chk("R1 cfg default", v, 32'h3C0);
    rd(3'd2, v); chk("R1 stat default", v, 32'hA);
    rd(3'd5, v); chk("R1 sys default", v, 32'h0);
    chk("R1 cs idle", {31'b0, cs}, 32'h1);
    chk("R1 sclk idle", {31'b0, sclk}, 32'h0);
    chk("R1 pins undriven", {30'b0, d0_oe, d1_oe}, 32'h0);
  endtask

  task automatic t_gating;
    logic [31:0] v;
    int e0;
    wr(3'd1, 32'h1);
    arm_slave(32'h0F);
    e0 = nedge;
    wr(3'd3, 32'h55);
    repeat (60) @(negedge clk);
    chk("R13 slave mode no clock", nedge, e0);
    rd(3'd2, v); chk("R13 txs held low in slave mode", {31'b0, v[1]}, 32'h0);
    wr(3'd1, 32'h0);
    wr(3'd5, 32'h2);
    repeat (60) @(negedge clk);
    chk("R13 disabled no clock", nedge, e0);
    wr(3'd1, 32'h1);
    wait_stat(1);
    wait_stat(2);
    s_act = 0;
    chk("R13 word sent once enabled", s_cap[0], 32'h55);
    rd(3'd2, v); chk("R5 rxs set", {31'b0, v[0]}, 32'h1);
    chk("R9 eot and txs after word", {30'b0, v[2:1]}, 32'h3);
    rd(3'd4, v); chk("R5 rx data", v, 32'h0F);
    rd(3'd2, v); chk("R5 rxs cleared by read", {31'b0, v[0]}, 32'h0);
  endtask

  task automatic t_txs;
    logic [31:0] v;
    wr(3'd1, 32'h0);
    wr(3'd3, 32'h11);
    rd(3'd2, v); chk("R8 txs low after write", {31'b0, v[1]}, 32'h0);
    arm_slave(32'h0);
    wr(3'd1, 32'h1);
    wait_stat(1);
    rd(3'd2, v); chk("R9 eot low while shifting", {31'b0, v[2]}, 32'h0);
    wait_stat(2);
    s_act = 0;
    rd(3'd4, v);
  endtask

  task automatic t_modes;
    logic [31:0] v;
    logic [31:0] tw [4] = '{32'h00, 32'hC3, 32'h1E, 32'h96};
    logic [31:0] sw [4] = '{32'h00, 32'h5A, 32'hE1, 32'h0D};
    for (int m = 1; m < 4; m++) begin
      set_cfg(mkcfg(1, 0, 0, 8, 1, 1, m[1], m[0]));
      chk("R3 sclk idles at pol", {31'b0, sclk}, {31'b0, m[1]});
      one_word(tw[m], sw[m], v);
      chk("R3 mode rx", v, sw[m]);
      chk("R3 mode tx", s_cap[0], tw[m]);
      chk("R3 sclk back to idle", {31'b0, sclk}, {31'b0, m[1]});
    end
  endtask

  task automatic t_lengths;
    logic [31:0] v;
    int   lens [3] = '{4, 12, 32};
    logic [31:0] tw [3] = '{32'hFFFF_FFF9, 32'hABC, 32'hDEAD_BEEF};
    logic [31:0] sw [3] = '{32'h6, 32'h5A3, 32'h8001_2345};
    for (int k = 0; k < 3; k++) begin
      set_cfg(mkcfg(1, 0, 0, lens[k], 1, 0, 0, 0));
      one_word(tw[k], sw[k], v);
      chk("R4 length rx zero-extended", v, sw[k] & msk(lens[k]));
      chk("R4 length tx", s_cap[0], tw[k] & msk(lens[k]));
    end
  endtask

  task automatic t_txonly;
    logic [31:0] v;
    set_cfg(mkcfg(1, 0, 0, 8, 1, 0, 0, 0));
    one_word(32'h33, 32'h77, v);
    set_cfg(mkcfg(1, 0, 2, 8, 1, 0, 0, 0));
    one_word(32'hB4, 32'hEE, v);
    chk("R6 tx-only data out", s_cap[0], 32'hB4);
    chk("R6 rxd unchanged", v, 32'h77);
    rd(3'd2, v); chk("R6 no rxs", {31'b0, v[0]}, 32'h0);
  endtask

  task automatic t_rxonly;
    logic [31:0] v;
    int e0;
    set_cfg(mkcfg(1, 0, 1, 8, 1, 2, 0, 0));
    arm_slave(32'h21);
    s_words[1] = 32'h42; s_words[2] = 32'h84; s_words[3] = 32'h19; s_words[4] = 32'hFF;
    wr(3'd3, 32'hFF);
    for (int k = 0; k < 3; k++) begin
      wait_stat(0);
      rd(3'd4, v);
      chk("R7 rx-only word", v, s_words[k]);
    end
    wr(3'd1, 32'h0);
    wait_stat(2);
    rd(3'd4, v); chk("R7 word in flight completes", v, 32'h19);
    e0 = nedge;
    repeat (200) @(negedge clk);
    chk("R7 no clocking after disable", nedge, e0);
    chk("R7 exactly four words", s_wi, 4);
    for (int k = 0; k < 4; k++) chk("R7 dummy zeros out", s_cap[k], 32'h0);
    s_act = 0;
    wr(3'd1, 32'h1);
  endtask

  task automatic t_divider;
    logic [31:0] v;
    realtime t0, t1;
    int codes [2] = '{3, 15};
    int exp   [2] = '{8, 4096};
    for (int k = 0; k < 2; k++) begin
      set_cfg(mkcfg(1, 0, 0, 4, 1, codes[k], 0, 0));
      arm_slave(32'h5);
      wr(3'd3, 32'hA);
      @(posedge sclk); t0 = $realtime;
      @(negedge sclk); t1 = $realtime;
      chk("R2 half period", int'((t1 - t0) / 10.0), exp[k]);
      wait_stat(2);
      s_act = 0;
      rd(3'd4, v);
    end
  endtask

  task automatic t_cs;
    set_cfg(mkcfg(1, 0, 0, 8, 1, 0, 0, 0));
    #1 chk("R10 forced active-low", {31'b0, cs}, 32'h0);
    set_cfg(mkcfg(1, 0, 0, 8, 0, 0, 0, 0));
    #1 chk("R10 forced active-high", {31'b0, cs}, 32'h1);
    set_cfg(mkcfg(0, 0, 0, 8, 0, 0, 0, 0));
    #1 chk("R10 released active-high", {31'b0, cs}, 32'h0);
  endtask

  task automatic t_swap;
    logic [31:0] v;
    set_cfg(mkcfg(1, 1, 0, 8, 1, 0, 0, 0));
    #1 chk("R11 swapped enables", {30'b0, d0_oe, d1_oe}, 32'h2);
    one_word(32'h6C, 32'h93, v);
    chk("R11 swapped rx from d1", v, 32'h93);
    chk("R11 swapped tx on d0", s_cap[0], 32'h6C);
    set_cfg(mkcfg(1, 0, 0, 8, 1, 0, 0, 0));
    #1 chk("R11 normal enables", {30'b0, d0_oe, d1_oe}, 32'h1);
  endtask

  task automatic t_softreset;
    logic [31:0] v;
    set_cfg(mkcfg(1, 1, 2, 16, 0, 5, 1, 1));
    wr(3'd5, 32'h3);
    reg_addr = 3'd2;
    #1 chk("R12 reset-done low after write", {31'b0, reg_rdata[3]}, 32'h0);
    rd(3'd2, v); chk("R12 stat after soft reset", v, 32'hA);
    rd(3'd0, v); chk("R12 cfg restored", v, 32'h3C0);
    rd(3'd5, v); chk("R12 back in slave mode", v, 32'h0);
    chk("R12 pins released", {30'b0, d0_oe, d1_oe}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_gating();
    t_txs();
    t_modes();
    t_lengths();
    t_txonly();
    t_rxonly();
    t_cs();
    t_swap();
    t_divider();
    t_softreset();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule